// File: doc/BRIEF.md
# Ratio-Corrected NCO Tuning Unit

This block keeps a 64-bit phase accumulator on its target frequency even though the clock that paces the oscillator drifts. Two oscillator signals come in as plain levels. One is the drifting local clock and the other is a stable reference. Each passes through a synchronizer and a rising-edge detector, and the edges are counted over back-to-back gate windows of fixed length in system clock cycles.

When a window closes, the nominal increment (the upper word of the step) is multiplied by the local count. The product is handed to a sequential divider, which divides it by the reference count. The quotient becomes the new upper word of the phase step, and the lower word of the step is always zero.

Until the first correction is ready, the accumulator steps by the nominal increment. If a window sees no reference edges, the current step is kept and an error flag is raised. The initial phase is loaded at reset and on a load strobe.

Top module: `nco_ratio_tuner`

## Requirements
- R1: While reset is high and in the cycle after it falls, `phase_out` equals `init_phase` and `ratio_err` is 0. From then on, the phase advances each cycle by `{nom_inc_hi, 32'h0}`.
- R2: A cycle with `phase_load` high makes `phase_out` equal the `init_phase` value that was sampled at that edge, one cycle later.
- R3: Each cycle without reset or load, `phase_out` grows by the current step modulo 2^64. The low 32 bits of the step are zero, so `phase_out[31:0]` changes only on reset or load.
- R4: Until the first correction completes, the step's upper word follows `nom_inc_hi`.
- R5: Rising edges of `lo_in` and `ref_in` are counted after a two-flop synchronizer. The counting runs over consecutive windows of `GATE_CYCLES` system cycles with no gap between windows.
- R6: After a window with local count L and reference count R > 0, the step's upper word becomes floor(nom_inc_hi * L / R). The product is formed at full width before the division.
- R7: A quotient that does not fit in 32 bits is saturated to 32'hFFFF_FFFF.
- R8: A window with a reference count of zero starts no division, leaves the step unchanged, and sets `ratio_err` in the next cycle.
- R9: A window with a nonzero reference count clears `ratio_err` in the next cycle.
- R10: The new step reaches the accumulator in a single clock edge. Between corrections, the step does not change.
- R11: The divider yields one quotient bit per clock over 32 + CNT_W cycles and is idle again before the next window closes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_in | input | 1 | Drifting local oscillator level, asynchronous |
| ref_in | input | 1 | Stable reference oscillator level, asynchronous |
| nom_inc_hi | input | 32 | Nominal upper word of the phase step |
| init_phase | input | 64 | Phase value loaded at reset or on load |
| phase_load | input | 1 | Loads `init_phase` into the accumulator |
| phase_out | output | 64 | Registered accumulator phase |
| ratio_err | output | 1 | Last window saw no reference edges |

## Verification
The assertions check several properties on every cycle. They check that the low phase word stays fixed between loads, that a load lands one cycle later, and that the step never moves except on a divider completion. They also check that the error flag follows the reference count of each closing window, and that the divider is idle when a window closes. The arithmetic itself can only be shown by the bench's scenarios, which drive oscillators whose periods divide the gate window: the exact counted totals, the quotient value, its saturation, the nominal step before the first update, and the recovery once reference edges resume.

// File: rtl/nrt_pkg.sv
package nrt_pkg;
  localparam int PH_W   = 64;
  localparam int WORD_W = 32;
  typedef logic [PH_W-1:0]   phase_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/nrt_edge_sync.sv
module nrt_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [2:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '0;
    else     stg <= {stg[1:0], din};
  end

  // stg[0], stg[1] form the synchronizer; stg[2] is the delayed copy
  assign rise = stg[1] & ~stg[2];
endmodule

// File: rtl/nrt_gate_counter.sv
module nrt_gate_counter #(
  parameter int GATE_CYCLES = 400000,
  parameter int N_CH        = 2,
  parameter int CNT_W       = 19
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_CH-1:0]            pulse,
  output logic                       win_done,
  output logic [N_CH-1:0][CNT_W-1:0] total
);
  localparam int WIN_W = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(GATE_CYCLES - 1);

  logic [WIN_W-1:0] win_cnt;
  logic             closing;

  assign closing = (win_cnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt  <= '0;
      win_done <= 1'b0;
    end else begin
      win_done <= closing;
      win_cnt  <= closing ? '0 : win_cnt + 1'b1;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [CNT_W-1:0] acc;
    always_ff @(posedge clk) begin
      if (rst) begin
        acc      <= '0;
        total[c] <= '0;
      end else if (closing) begin
        total[c] <= acc + CNT_W'(pulse[c]);
        acc      <= '0;
      end else begin
        acc <= acc + CNT_W'(pulse[c]);
      end
    end
  end
endmodule

// File: rtl/nrt_divider.sv
module nrt_divider #(
  parameter int DW = 51,
  parameter int VW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quotient
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] dvd;
  logic [VW-1:0] dvs;
  logic [VW-1:0] rem;
  logic [CW-1:0] bit_left;
  logic [VW:0]   shifted;
  logic [VW:0]   trial;
  logic          qbit;
  logic [VW-1:0] rem_nxt;

  always_comb begin
    shifted = {rem, dvd[DW-1]};
    trial   = shifted - {1'b0, dvs};
    qbit    = (shifted >= {1'b0, dvs});
    rem_nxt = qbit ? trial[VW-1:0] : shifted[VW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      dvd      <= '0;
      dvs      <= '0;
      rem      <= '0;
      quotient <= '0;
      bit_left <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        dvd      <= dividend;
        dvs      <= divisor;
        rem      <= '0;
        quotient <= '0;
        bit_left <= CW'(DW - 1);
        busy     <= 1'b1;
      end else if (busy) begin
        rem      <= rem_nxt;
        quotient <= {quotient[DW-2:0], qbit};
        dvd      <= {dvd[DW-2:0], 1'b0};
        if (bit_left == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          bit_left <= bit_left - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nrt_phase_accum.sv
module nrt_phase_accum
  import nrt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  phase_t init,
  input  word_t  step_hi,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (rst || load) phase <= init;
    else             phase <= phase + {step_hi, {WORD_W{1'b0}}};
  end
endmodule

// File: rtl/nco_ratio_tuner.sv
module nco_ratio_tuner
  import nrt_pkg::*;
#(
  parameter int GATE_CYCLES = 400000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lo_in,
  input  logic         ref_in,
  input  logic [31:0]  nom_inc_hi,
  input  logic [63:0]  init_phase,
  input  logic         phase_load,
  output logic [63:0]  phase_out,
  output logic         ratio_err
);
  localparam int CNT_W = $clog2(GATE_CYCLES + 1);
  localparam int DW    = WORD_W + CNT_W;
  localparam int LO    = 0;
  localparam int RF    = 1;

  logic [1:0]            osc_raw;
  logic [1:0]            osc_rise;
  logic [1:0][CNT_W-1:0] counts;
  logic                  gate_done;
  logic [CNT_W-1:0]      ref_cnt;
  logic [DW-1:0]         product;
  logic                  div_start;
  logic                  div_busy;
  logic                  div_done;
  logic [DW-1:0]         quo;
  word_t                 inc_hi;
  word_t                 corr_hi;
  logic                  have_corr;

  assign osc_raw = {ref_in, lo_in};

  for (genvar c = 0; c < 2; c++) begin : g_sync
    nrt_edge_sync u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (osc_raw[c]),
      .rise (osc_rise[c])
    );
  end

  nrt_gate_counter #(
    .GATE_CYCLES (GATE_CYCLES),
    .N_CH        (2),
    .CNT_W       (CNT_W)
  ) u_gate (
    .clk      (clk),
    .rst      (rst),
    .pulse    (osc_rise),
    .win_done (gate_done),
    .total    (counts)
  );

  assign ref_cnt   = counts[RF];
  // multiply first: the full product keeps every bit for the divide
  assign product   = {{CNT_W{1'b0}}, nom_inc_hi} * {{WORD_W{1'b0}}, counts[LO]};
  assign div_start = gate_done && (ref_cnt != '0) && !div_busy;

  nrt_divider #(
    .DW (DW),
    .VW (CNT_W)
  ) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (product),
    .divisor  (ref_cnt),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (quo)
  );

  assign corr_hi = (|quo[DW-1:WORD_W]) ? {WORD_W{1'b1}} : quo[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_hi    <= nom_inc_hi;
      have_corr <= 1'b0;
      ratio_err <= 1'b0;
    end else begin
      if (div_done) begin
        inc_hi    <= corr_hi;
        have_corr <= 1'b1;
      end else if (!have_corr) begin
        inc_hi <= nom_inc_hi;
      end
      if (gate_done) ratio_err <= (ref_cnt == '0);
    end
  end

  nrt_phase_accum u_acc (
    .clk     (clk),
    .rst     (rst),
    .load    (phase_load),
    .init    (init_phase),
    .step_hi (inc_hi),
    .phase   (phase_out)
  );
endmodule

// File: rtl/nrt_checker.sv
module nrt_checker #(
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             phase_load,
  input logic [63:0]      init_phase,
  input logic [63:0]      phase_out,
  input logic             ratio_err,
  input logic             gate_done,
  input logic [CNT_W-1:0] ref_cnt,
  input logic             div_busy,
  input logic             div_done,
  input logic [31:0]      inc_hi,
  input logic             have_corr
);
  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (rst)
    phase_load |=> phase_out == $past(init_phase));

  // R3
  low_word_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(phase_load) |-> phase_out[31:0] == $past(phase_out[31:0]));

  // R8
  zero_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_done && ref_cnt == '0) |=> (ratio_err && !div_busy));

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_done && ref_cnt != '0) |=> !ratio_err);

  // R11
  div_idle_at_close_chk: assert property (@(posedge clk) disable iff (rst)
    gate_done |-> !div_busy);

  // R10
  step_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (have_corr && !div_done) |=> $stable(inc_hi));

  // R4
  first_corr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(have_corr) |-> $past(div_done));
endmodule

bind nco_ratio_tuner nrt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase_load (phase_load),
  .init_phase (init_phase),
  .phase_out  (phase_out),
  .ratio_err  (ratio_err),
  .gate_done  (gate_done),
  .ref_cnt    (ref_cnt),
  .div_busy   (div_busy),
  .div_done   (div_done),
  .inc_hi     (inc_hi),
  .have_corr  (have_corr)
);

// File: tb/tb_nco_ratio_tuner.sv
`timescale 1ns/1ps
module tb_nco_ratio_tuner;
  localparam int G  = 240;
  localparam int DW = 32 + $clog2(G + 1);

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lo_in = 1'b0;
  logic        ref_in = 1'b0;
  logic [31:0] nom_inc_hi = '0;
  logic [63:0] init_phase = '0;
  logic        phase_load = 1'b0;
  logic [63:0] phase_out;
  logic        ratio_err;

  always #2 clk = ~clk;

  nco_ratio_tuner #(.GATE_CYCLES(G)) dut (
    .clk(clk), .rst(rst), .lo_in(lo_in), .ref_in(ref_in),
    .nom_inc_hi(nom_inc_hi), .init_phase(init_phase),
    .phase_load(phase_load), .phase_out(phase_out), .ratio_err(ratio_err)
  );

  int checks = 0;
  int errors = 0;
  int plo = 0;
  int pref = 0;
  int gcnt = 0;
  int cyc = 0;
  int first_upd = -1;
  bit lenient = 1'b0;
  logic [63:0] prev_ph = '0;
  logic [63:0] last_delta = '0;
  logic [63:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] calc(input logic [31:0] nom, input int l, input int r);
    logic [95:0] q;
    q = ({64'h0, nom} * 96'(l)) / 96'(r);
    if (q > 96'hFFFF_FFFF) return {32'hFFFF_FFFF, 32'h0};
    return {q[31:0], 32'h0};
  endfunction

  // oscillator generator, levels set on the falling edge
  initial forever begin
    @(negedge clk);
    if (rst) gcnt = 0; else gcnt++;
    lo_in  = (plo  != 0) && ((gcnt % (plo  == 0 ? 1 : plo))  >= plo / 2);
    ref_in = (pref != 0) && ((gcnt % (pref == 0 ? 1 : pref)) >= pref / 2);
  end

  // monitor: per-cycle phase step compared against the expected queue
  initial forever begin
    @(negedge clk);
    if (rst) cyc = 0; else cyc++;
    if (!rst && !phase_load && exp_q.size() > 0) begin
      last_delta = phase_out - prev_ph;
      if (!lenient) begin
        if (last_delta == exp_q[0]) begin
        end else if (exp_q.size() > 1 && last_delta == exp_q[1]) begin
          void'(exp_q.pop_front());
          if (first_upd < 0) first_upd = cyc;
          chk(1'b1, "R6", last_delta, last_delta);
        end else begin
          chk(1'b0, "R3 R5 R6 R10 step", last_delta, exp_q[0]);
        end
      end
    end
    prev_ph = phase_out;
  end

  task automatic start_scn(input logic [31:0] nom, input logic [63:0] init,
                           input int l_p, input int r_p);
    @(negedge clk); #1;
    rst = 1'b1; nom_inc_hi = nom; init_phase = init; plo = l_p; pref = r_p;
    lenient = 1'b0; first_upd = -1;
    exp_q.delete();
    exp_q.push_back({nom, 32'h0});
    if (r_p != 0) exp_q.push_back(calc(nom, G / l_p, G / r_p));
    repeat (4) @(negedge clk);
    chk(phase_out == init, "R1 reset phase", phase_out, init);
    chk(ratio_err == 1'b0, "R1 reset err", {63'h0, ratio_err}, 64'h0);
    #1 rst = 1'b0;
  endtask

  task automatic wait_windows(input int n);
    repeat (n * G + 60) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Scenario A: local slower than reference
    start_scn(32'h1000_0000, 64'h0, 12, 10);
    repeat (20) @(negedge clk);
    chk(last_delta == {32'h1000_0000, 32'h0}, "R4 nominal before first window",
        last_delta, {32'h1000_0000, 32'h0});
    wait_windows(4);
    chk(exp_q.size() == 1, "R5 R6 correction seen", 64'(exp_q.size()), 64'd1);
    chk(first_upd > G && first_upd <= G + DW + 8, "R11 correction latency",
        64'(first_upd), 64'(G + DW));
    chk(last_delta == calc(32'h1000_0000, 20, 24), "R6 steady step",
        last_delta, calc(32'h1000_0000, 20, 24));

    // Scenario B: local faster, with a mid-run load
    start_scn(32'h1234_5678, 64'h0000_0001_0000_0005, 8, 12);
    wait_windows(2);
    @(negedge clk); #1;
    init_phase = 64'h0123_4567_89AB_CDEF;
    phase_load = 1'b1;
    @(negedge clk); #1;
    phase_load = 1'b0;
    chk(phase_out == 64'h0123_4567_89AB_CDEF, "R2 load", phase_out,
        64'h0123_4567_89AB_CDEF);
    wait_windows(2);
    chk(phase_out[31:0] == 32'h89AB_CDEF, "R3 low word held",
        {32'h0, phase_out[31:0]}, 64'h89AB_CDEF);
    chk(exp_q.size() == 1, "R6 correction seen B", 64'(exp_q.size()), 64'd1);
    chk(last_delta == calc(32'h1234_5678, 30, 20), "R6 R10 step B",
        last_delta, calc(32'h1234_5678, 30, 20));

    // Scenario C: quotient overflow
    start_scn(32'h8000_0000, 64'h0, 8, 24);
    wait_windows(3);
    chk(last_delta == {32'hFFFF_FFFF, 32'h0}, "R7 saturation", last_delta,
        {32'hFFFF_FFFF, 32'h0});

    // Scenario D: no reference edges, then recovery
    start_scn(32'h0BAD_CAFE, 64'h0, 12, 0);
    wait_windows(3);
    chk(ratio_err == 1'b1, "R8 err set", {63'h0, ratio_err}, 64'h1);
    chk(last_delta == {32'h0BAD_CAFE, 32'h0}, "R8 step kept", last_delta,
        {32'h0BAD_CAFE, 32'h0});
    lenient = 1'b1;
    pref = 10;
    wait_windows(4);
    chk(ratio_err == 1'b0, "R9 err cleared", {63'h0, ratio_err}, 64'h0);
    chk(last_delta == calc(32'h0BAD_CAFE, 20, 24), "R6 step after recovery",
        last_delta, calc(32'h0BAD_CAFE, 20, 24));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule